// File: doc/BRIEF.md
# Control List Pending-Work Flag Handshake

This block keeps a single "work pending" flag that host software and a list-processing engine share to decide whether the control transfer list needs another pass. Software raises the flag through a register write whenever it queues a new transfer descriptor. The engine asks for permission each time it arrives at the head of the list. If the flag is clear, the block tells the engine to skip the list. If the flag is set, the block lets the pass run and clears the flag in the same step.

While a pass is running, the engine pulses a "found" input for every descriptor it meets, and the block raises the flag again. When the engine reports the end of the pass, the block answers with a one-cycle "continue" pulse if the flag is set or a "stop" pulse if it is still clear. A descriptor that software queues while the pass runs is never lost: a software set beats a hardware clear that lands in the same cycle.

The block holds no list state and fetches nothing from memory. It only arbitrates the flag and reports the pass decisions.

Top module: `list_fill_handshake`

## Requirements
- R1: After reset the flag is 0, `regRdData` is all zero, `passActive` is 0 and the four result pulses `runPulse`, `skipPulse`, `contPulse` and `stopPulse` are 0.
- R2: A register write (`regWrEn`=1) with bit 1 of `regWrData` at 1 sets the flag from the next cycle. The flag is read back at bit 1 of `regRdData`.
- R3: A register write with bit 1 at 0 leaves the flag unchanged, whatever the other bits hold. All bits of `regRdData` except bit 1 always read 0.
- R4: `headReq` while no pass is active and the flag is 0 gives a one-cycle `skipPulse` in the next cycle. No pass starts and the flag stays 0.
- R5: `headReq` while no pass is active and the flag is 1 gives a one-cycle `runPulse` in the next cycle. `passActive` rises and the hardware clears the flag.
- R6: `tdFound` during an active pass sets the flag from the next cycle. `tdFound` while no pass is active has no effect.
- R7: `passDone` during an active pass ends the pass. In the next cycle exactly one of `contPulse` (flag is 1 after that cycle's updates, including any `tdFound` or software set in the same cycle) or `stopPulse` (flag is 0) is high for one cycle.
- R8: When a software set and the hardware clear of R5 occur in the same cycle, the flag ends up 1. The pass still starts.
- R9: `headReq` during an active pass and `passDone` while no pass is active are ignored: no pulse is produced and neither the flag nor `passActive` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | DATA_W | Register write data; bit 1 = 1 sets the flag |
| regRdData | output | DATA_W | Register read data; flag at bit 1, other bits 0 |
| headReq | input | 1 | Engine has reached the head of the list |
| tdFound | input | 1 | Engine found a descriptor during the pass |
| passDone | input | 1 | Engine finished the pass |
| passActive | output | 1 | A pass is in progress |
| runPulse | output | 1 | Head request granted, pass runs |
| skipPulse | output | 1 | Head request refused, list skipped |
| contPulse | output | 1 | Pass ended with the flag set: process again |
| stopPulse | output | 1 | Pass ended with the flag clear: processing stops |

## Verification
A wrong flag value shows at bit 1 of `regRdData` one cycle after the write, head request or found pulse that caused it. A wrong pass state shows on `passActive` one cycle after the event, and on the next head or done answer as a missing or extra result pulse. The collision cases (software set against hardware clear, found together with done, head during a pass) are where a priority mistake would surface. Each one is followed by a readback in the next cycle, so an error is visible within one or two cycles.

// File: rtl/lfh_pkg.sv
package lfh_pkg;

  // Hardware flag commands issued by the pass controller to the flag datapath
  typedef struct packed {
    logic hwSet;   // descriptor found during a pass
    logic hwClr;   // pass granted at list head
  } flagCmd_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_PASS = 1'b1
  } passState_t;

endpackage

// File: rtl/lfh_flag_dp.sv
module lfh_flag_dp
  import lfh_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int FLAG_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  flagCmd_t          cmd,
  output logic              flagQ,
  output logic              flagNext,
  output logic [DATA_W-1:0] regRdData
);

  logic swSet;

  // Only a written 1 at the flag position matters; zeros are ignored (R3)
  assign swSet = regWrEn && regWrData[FLAG_BIT];

  // Sets dominate the hardware clear, so a new descriptor is never lost (R8)
  always_comb begin
    if (swSet || cmd.hwSet)
      flagNext = 1'b1;
    else if (cmd.hwClr)
      flagNext = 1'b0;
    else
      flagNext = flagQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flagQ <= 1'b0;
    else        flagQ <= flagNext;
  end

  always_comb begin
    regRdData           = '0;
    regRdData[FLAG_BIT] = flagQ;
  end

  p_sw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    swSet |=> flagQ);

  p_zero_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && !regWrData[FLAG_BIT] && !cmd.hwSet && !cmd.hwClr) |=> (flagQ == $past(flagQ)));

  p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (swSet && cmd.hwClr) |=> flagQ);

endmodule

// File: rtl/lfh_pass_ctrl.sv
module lfh_pass_ctrl
  import lfh_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     headReq,
  input  logic     tdFound,
  input  logic     passDone,
  input  logic     flagQ,
  input  logic     flagNext,
  output flagCmd_t cmd,
  output logic     passActive,
  output logic     runPulse,
  output logic     skipPulse,
  output logic     contPulse,
  output logic     stopPulse
);

  passState_t state, stateNext;
  logic headAccept;
  logic doneAccept;

  assign headAccept = headReq && (state == ST_IDLE);
  assign doneAccept = passDone && (state == ST_PASS);

  always_comb begin
    cmd.hwClr = headAccept && flagQ;
    cmd.hwSet = tdFound && (state == ST_PASS);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (headAccept && flagQ) stateNext = ST_PASS;
      ST_PASS: if (doneAccept)          stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      runPulse  <= 1'b0;
      skipPulse <= 1'b0;
      contPulse <= 1'b0;
      stopPulse <= 1'b0;
    end else begin
      state     <= stateNext;
      runPulse  <= headAccept && flagQ;
      skipPulse <= headAccept && !flagQ;
      contPulse <= doneAccept && flagNext;
      stopPulse <= doneAccept && !flagNext;
    end
  end

  assign passActive = (state == ST_PASS);

  p_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (headReq && !passActive && !flagQ) |=> (skipPulse && !passActive));

  p_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (headReq && !passActive && flagQ) |=> (runPulse && passActive));

  p_found_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tdFound && passActive) |=> flagQ);

  p_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (passDone && passActive) |=> (!passActive && (contPulse || stopPulse)));

  p_one_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({runPulse, skipPulse, contPulse, stopPulse}));

  p_head_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (headReq && passActive && !passDone) |=> (!runPulse && !skipPulse && passActive));

endmodule

// File: rtl/list_fill_handshake.sv
module list_fill_handshake
  import lfh_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int FLAG_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              headReq,
  input  logic              tdFound,
  input  logic              passDone,
  output logic              passActive,
  output logic              runPulse,
  output logic              skipPulse,
  output logic              contPulse,
  output logic              stopPulse
);

  flagCmd_t cmd;
  logic     flagQ;
  logic     flagNext;

  lfh_flag_dp #(
    .DATA_W  (DATA_W),
    .FLAG_BIT(FLAG_BIT)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .cmd      (cmd),
    .flagQ    (flagQ),
    .flagNext (flagNext),
    .regRdData(regRdData)
  );

  lfh_pass_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .headReq   (headReq),
    .tdFound   (tdFound),
    .passDone  (passDone),
    .flagQ     (flagQ),
    .flagNext  (flagNext),
    .cmd       (cmd),
    .passActive(passActive),
    .runPulse  (runPulse),
    .skipPulse (skipPulse),
    .contPulse (contPulse),
    .stopPulse (stopPulse)
  );

endmodule

// File: tb/test_list_fill_handshake.sv
module test_list_fill_handshake;

  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              regWrEn;
  logic [DATA_W-1:0] regWrData;
  logic [DATA_W-1:0] regRdData;
  logic              headReq, tdFound, passDone;
  logic              passActive, runPulse, skipPulse, contPulse, stopPulse;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  list_fill_handshake #(.DATA_W(DATA_W), .FLAG_BIT(1)) i_list_fill_handshake (
    .clk(clk), .rst_n(rst_n),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .headReq(headReq), .tdFound(tdFound), .passDone(passDone),
    .passActive(passActive), .runPulse(runPulse), .skipPulse(skipPulse),
    .contPulse(contPulse), .stopPulse(stopPulse)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] wd;
    logic       head;
    logic       found;
    logic       done;
    logic       eFlag;
    logic       eAct;
    logic       eRun;
    logic       eSkip;
    logic       eCont;
    logic       eStop;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    // wr  wd     hd    fd    dn    flag  act   run   skip  cont  stop  req
    '{1'b0,8'h00,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 4'd4}, // R4 skip
    '{1'b1,8'h02,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd2}, // R2 set
    '{1'b1,8'hFD,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd3}, // R3 zero write
    '{1'b0,8'h00,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 4'd5}, // R5 run
    '{1'b0,8'h00,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 4'd6}, // R6 found
    '{1'b0,8'h00,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 4'd7}, // R7 cont
    '{1'b0,8'h00,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 4'd5}, // R5 run
    '{1'b0,8'h00,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 4'd5}, // R5 hold
    '{1'b0,8'h00,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 4'd7}, // R7 stop
    '{1'b0,8'h00,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd6}, // R6 idle found
    '{1'b1,8'h01,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd3}, // R3 other bit
    '{1'b1,8'h02,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd2}, // R2 set
    '{1'b1,8'h02,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 4'd8}, // R8 collision
    '{1'b0,8'h00,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 4'd7}, // R7 cont
    '{1'b0,8'h00,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 4'd5}, // R5 run
    '{1'b0,8'h00,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 4'd9}, // R9 head in pass
    '{1'b0,8'h00,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 4'd7}, // R7 found+done
    '{1'b0,8'h00,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 4'd5}, // R5 run
    '{1'b1,8'h02,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 4'd7}, // R7 sw set+done
    '{1'b0,8'h00,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd9}  // R9 idle done
  };

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idleInputs();
    regWrEn = 1'b0; regWrData = '0; headReq = 1'b0; tdFound = 1'b0; passDone = 1'b0;
  endtask

  task automatic checkOutputs(input string tag, input logic eFlag, input logic eAct,
                              input logic [3:0] ePulses);
    chk({tag, " rd"}, regRdData, {{(DATA_W-2){1'b0}}, eFlag, 1'b0});
    chk({tag, " active"}, {{(DATA_W-1){1'b0}}, passActive}, {{(DATA_W-1){1'b0}}, eAct});
    chk({tag, " pulses run/skip/cont/stop"},
        {{(DATA_W-4){1'b0}}, runPulse, skipPulse, contPulse, stopPulse},
        {{(DATA_W-4){1'b0}}, ePulses});
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idleInputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkOutputs("R1 reset", 1'b0, 1'b0, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      regWrEn   = VEC[i].wr;
      regWrData = {{(DATA_W-8){1'b0}}, VEC[i].wd};
      headReq   = VEC[i].head;
      tdFound   = VEC[i].found;
      passDone  = VEC[i].done;
      @(negedge clk);
      idleInputs();
      checkOutputs($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].eFlag, VEC[i].eAct,
                   {VEC[i].eRun, VEC[i].eSkip, VEC[i].eCont, VEC[i].eStop});
    end

    // R7: pulses last one cycle only
    @(negedge clk);
    checkOutputs("R7 pulse width", 1'b1, 1'b0, 4'b0000);

    // R1: reset in the middle of a pass clears everything
    headReq = 1'b1;
    @(negedge clk);
    idleInputs();
    regWrEn = 1'b1; regWrData = 32'h2;
    @(negedge clk);
    idleInputs();
    checkOutputs("R2 set in pass", 1'b1, 1'b1, 4'b0000);
    rst_n = 1'b0;
    @(negedge clk);
    checkOutputs("R1 mid-pass reset", 1'b0, 1'b0, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: all-ones write except the flag bit keeps flag set, upper bits read zero
    regWrEn = 1'b1; regWrData = 32'hFFFF_FFFF;
    @(negedge clk);
    regWrData = 32'hFFFF_FFFD;
    @(negedge clk);
    idleInputs();
    checkOutputs("R3 full-width write", 1'b1, 1'b0, 4'b0000);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule